// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Carry Flag

This block computes the next value of an 8-bit accumulator and its 1-bit carry flag. Each cycle it takes the present accumulator value, a memory operand byte, the present carry flag and a 4-bit operation code. It returns the new accumulator and the new flag. Fetching the operand and immediate addressing are left to the surrounding datapath. That datapath feeds the accumulator and flag outputs back into the inputs on the next operation.

The unit covers binary addition with and without carry-in, and subtraction in both directions with and without borrow. A borrow is carried as the inverse of the flag, so after a subtraction the flag reads 1 when no borrow occurred. It also covers logical shifts, rotates through the flag, the three bitwise logic operations and a plain load. The logic operations and the load leave the flag as it was. A single shared adder serves every arithmetic code. The result goes through an output register by default; a parameter bypasses it to give a purely combinational unit.

Top module: `acc_alu`

## Requirements
- R1: With `op` = 4 the outputs are `d_out` = low 8 bits of `m_in + d_in` and `df_out` = carry-out of that sum. With `op` = 9 the sum also includes `df_in`.
- R2: With `op` = 5 the result is `m_in - d_in`, and with `op` = 7 it is `d_in - m_in`. In both cases `df_out` is 1 exactly when the minuend is greater than or equal to the subtrahend (no borrow).
- R3: With `op` = 10 the result is `m_in - d_in - (1 - df_in)`, and with `op` = 11 it is `d_in - m_in - (1 - df_in)`. In both cases `df_out` is 1 exactly when no borrow occurs.
- R4: With `op` = 6, `d_in` shifts right, bit 0 goes to `df_out` and bit 7 becomes 0. With `op` = 13, `d_in` shifts left, bit 7 goes to `df_out` and bit 0 becomes 0.
- R5: With `op` = 12, `d_in` rotates right through the flag: `df_in` enters bit 7 and bit 0 goes to `df_out`. With `op` = 14, `d_in` rotates left through the flag: `df_in` enters bit 0 and bit 7 goes to `df_out`.
- R6: Code 0 loads `m_in` into `d_out`, and codes 1, 2 and 3 give `m_in` OR, AND and XOR `d_in`. All four pass `df_in` unchanged to `df_out`.
- R7: Codes 8 and 15 change nothing: `d_out` = `d_in` and `df_out` = `df_in`.
- R8: With the output register enabled (the default), the result appears one clock after the inputs are sampled. While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset of the output register |
| op | input | 4 | Operation code |
| d_in | input | 8 | Present accumulator value |
| m_in | input | 8 | Memory or immediate operand |
| df_in | input | 1 | Present carry flag |
| d_out | output | 8 | New accumulator value |
| df_out | output | 1 | New carry flag |

## Verification
Two uses of the flag can meet in one cycle. On a carry-in or borrow code, the flag produced by the previous operation is consumed in the same cycle in which the unit writes a new flag; a rotate both reads and writes the flag in a single operation. The bench provokes both cases by feeding `d_out` and `df_out` back as inputs on consecutive cycles. It chains a 32-bit add and subtract byte by byte, and it rotates a byte through the flag nine times. Each byte is judged against the same arithmetic done in full width in the bench, and the nine rotations must bring back the starting pattern and flag.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] d_in,
  input  logic [WIDTH-1:0] m_in,
  input  logic             df_in,
  output logic [WIDTH-1:0] d_out,
  output logic             df_out
);
  localparam logic [3:0] OP_LOAD = 4'h0;
  localparam logic [3:0] OP_OR   = 4'h1;
  localparam logic [3:0] OP_AND  = 4'h2;
  localparam logic [3:0] OP_XOR  = 4'h3;
  localparam logic [3:0] OP_ADD  = 4'h4;
  localparam logic [3:0] OP_SUBD = 4'h5;
  localparam logic [3:0] OP_SHR  = 4'h6;
  localparam logic [3:0] OP_SUBM = 4'h7;
  localparam logic [3:0] OP_ADC  = 4'h9;
  localparam logic [3:0] OP_SDB  = 4'hA;
  localparam logic [3:0] OP_SMB  = 4'hB;
  localparam logic [3:0] OP_RORC = 4'hC;
  localparam logic [3:0] OP_SHL  = 4'hD;
  localparam logic [3:0] OP_ROLC = 4'hE;

  logic [WIDTH-1:0] add_a, add_b;
  logic             add_ci;
  logic [WIDTH:0]   add_sum;
  logic [WIDTH-1:0] nxt_d;
  logic             nxt_df;

  always_comb begin
    add_a  = m_in;
    add_b  = d_in;
    add_ci = 1'b0;
    unique case (op)
      OP_ADC:  add_ci = df_in;
      OP_SUBD: begin add_b = ~d_in; add_ci = 1'b1; end
      OP_SDB:  begin add_b = ~d_in; add_ci = df_in; end
      OP_SUBM: begin add_a = d_in; add_b = ~m_in; add_ci = 1'b1; end
      OP_SMB:  begin add_a = d_in; add_b = ~m_in; add_ci = df_in; end
      default: ;
    endcase
  end

  assign add_sum = {1'b0, add_a} + {1'b0, add_b} + {{WIDTH{1'b0}}, add_ci};

  always_comb begin
    nxt_d  = d_in;
    nxt_df = df_in;
    case (op)
      OP_LOAD: nxt_d = m_in;
      OP_OR:   nxt_d = m_in | d_in;
      OP_AND:  nxt_d = m_in & d_in;
      OP_XOR:  nxt_d = m_in ^ d_in;
      OP_ADD, OP_ADC, OP_SUBD, OP_SDB, OP_SUBM, OP_SMB:
               {nxt_df, nxt_d} = add_sum;
      OP_SHR:  {nxt_d, nxt_df} = {1'b0, d_in};
      OP_RORC: {nxt_d, nxt_df} = {df_in, d_in};
      OP_SHL:  {nxt_df, nxt_d} = {d_in, 1'b0};
      OP_ROLC: {nxt_df, nxt_d} = {d_in, df_in};
      default: ;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_out  <= '0;
          df_out <= 1'b0;
        end else begin
          d_out  <= nxt_d;
          df_out <= nxt_df;
        end
      end
    end else begin : g_comb
      assign d_out  = nxt_d;
      assign df_out = nxt_df;
    end
  endgenerate
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       op,
  input logic [WIDTH-1:0] d_in,
  input logic [WIDTH-1:0] m_in,
  input logic             df_in,
  input logic [WIDTH-1:0] d_out,
  input logic             df_out
);
  generate
    if (REG_OUT) begin : g_seq
      a_r1_add: assert property (@(posedge clk) disable iff (!rst_n)
        op == 4'h4 |=> {df_out, d_out} == ({1'b0, $past(m_in)} + {1'b0, $past(d_in)}));
      a_r2_subm_flag: assert property (@(posedge clk) disable iff (!rst_n)
        op == 4'h7 |=> df_out == ($past(d_in) >= $past(m_in)));
      a_r2_subd_flag: assert property (@(posedge clk) disable iff (!rst_n)
        op == 4'h5 |=> df_out == ($past(m_in) >= $past(d_in)));
      a_r4_shr: assert property (@(posedge clk) disable iff (!rst_n)
        op == 4'h6 |=> !d_out[WIDTH-1] && df_out == $past(d_in[0]));
      a_r5_rorc: assert property (@(posedge clk) disable iff (!rst_n)
        op == 4'hC |=> d_out[WIDTH-1] == $past(df_in) && df_out == $past(d_in[0]));
      a_r6_logic_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        op[3:2] == 2'b00 |=> df_out == $past(df_in));
      a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'h8 || op == 4'hF) |=> d_out == $past(d_in) && df_out == $past(df_in));
      a_r8_reset: assert property (@(posedge clk) !rst_n |-> d_out == '0 && !df_out);
    end else begin : g_comb
      always_comb begin
        if (op == 4'h8 || op == 4'hF)
          a_r7_hold_c: assert (d_out == d_in && df_out == df_in);
        if (op[3:2] == 2'b00)
          a_r6_keep_c: assert (df_out == df_in);
      end
    end
  endgenerate
endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .d_in(d_in), .m_in(m_in),
  .df_in(df_in), .d_out(d_out), .df_out(df_out)
);

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = 4'h8;
  logic [7:0] d_in = '0, m_in = '0;
  logic       df_in = 1'b0;
  logic [7:0] d_out;
  logic       df_out;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  acc_alu u0 (.clk(clk), .rst_n(rst_n), .op(op), .d_in(d_in), .m_in(m_in),
              .df_in(df_in), .d_out(d_out), .df_out(df_out));

  function automatic logic [8:0] model(input logic [3:0] o, input logic [7:0] d,
                                       input logic [7:0] m, input logic f);
    int a, b, r;
    a = int'(d); b = int'(m);
    case (o)
      4'h0: return {f, m};
      4'h1: return {f, m | d};
      4'h2: return {f, m & d};
      4'h3: return {f, m ^ d};
      4'h4: begin r = b + a; return {r > 255, 8'(r)}; end
      4'h9: begin r = b + a + int'(f); return {r > 255, 8'(r)}; end
      4'h5: begin r = b - a; return {r >= 0, 8'(r)}; end
      4'h7: begin r = a - b; return {r >= 0, 8'(r)}; end
      4'hA: begin r = b - a - (f ? 0 : 1); return {r >= 0, 8'(r)}; end
      4'hB: begin r = a - b - (f ? 0 : 1); return {r >= 0, 8'(r)}; end
      4'h6: return {d[0], 1'b0, d[7:1]};
      4'hD: return {d[7], d[6:0], 1'b0};
      4'hC: return {d[0], f, d[7:1]};
      4'hE: return {d[7], d[6:0], f};
      default: return {f, d};
    endcase
  endfunction

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got df=%0b d=%02h expected df=%0b d=%02h",
               req, got[8], got[7:0], exp[8], exp[7:0]);
    end
  endtask

  task automatic run(input string req, input logic [3:0] o, input logic [7:0] d,
                     input logic [7:0] m, input logic f);
    @(negedge clk);
    op = o; d_in = d; m_in = m; df_in = f;
    @(posedge clk);
    #1;
    check(req, {df_out, d_out}, model(o, d, m, f));
  endtask

  task automatic t_reset();
    #1;
    check("R8 reset", {df_out, d_out}, 9'h000);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_logic();
    run("R6 load", 4'h0, 8'h12, 8'hA5, 1'b1);
    run("R6 or",   4'h1, 8'h0F, 8'hA0, 1'b0);
    run("R6 and",  4'h2, 8'hF0, 8'h3C, 1'b1);
    run("R6 xor",  4'h3, 8'hFF, 8'h5A, 1'b0);
  endtask

  task automatic t_add();
    run("R1 add no carry", 4'h4, 8'h12, 8'h34, 1'b1);
    run("R1 add carry",    4'h4, 8'hF0, 8'h20, 1'b0);
    run("R1 adc edge",     4'h9, 8'hFF, 8'h00, 1'b1);
    run("R1 adc no cin",   4'h9, 8'h80, 8'h7F, 1'b0);
  endtask

  task automatic t_sub();
    run("R2 m-d equal",  4'h5, 8'h40, 8'h40, 1'b0);
    run("R2 m-d borrow", 4'h5, 8'h41, 8'h40, 1'b1);
    run("R2 d-m",        4'h7, 8'h90, 8'h10, 1'b0);
    run("R2 d-m borrow", 4'h7, 8'h00, 8'h01, 1'b1);
    run("R3 sdb df0",    4'hA, 8'h10, 8'h10, 1'b0);
    run("R3 sdb df1",    4'hA, 8'h10, 8'h10, 1'b1);
    run("R3 smb df0",    4'hB, 8'h35, 8'h12, 1'b0);
    run("R3 smb edge",   4'hB, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_shift();
    run("R4 shr", 4'h6, 8'h81, 8'h00, 1'b1);
    run("R4 shl", 4'hD, 8'h81, 8'h00, 1'b1);
    run("R5 rorc", 4'hC, 8'h02, 8'h00, 1'b1);
    run("R5 rolc", 4'hE, 8'h40, 8'h00, 1'b1);
    run("R5 rolc msb", 4'hE, 8'h80, 8'h00, 1'b0);
  endtask

  task automatic t_hold();
    run("R7 code 8", 4'h8, 8'h5C, 8'hFF, 1'b1);
    run("R7 code 15", 4'hF, 8'hC5, 8'h00, 1'b0);
  endtask

  task automatic t_chain();
    logic [31:0] a = 32'h89ABCDEF, b = 32'h76543211, s;
    logic [32:0] full;
    logic f;
    full = {1'b0, a} + {1'b0, b};
    for (int i = 0; i < 4; i++) begin
      run("R1 chain", (i == 0) ? 4'h4 : 4'h9, a[i*8 +: 8], b[i*8 +: 8], (i == 0) ? 1'b0 : df_out);
      checks++;
      if (d_out !== full[i*8 +: 8]) begin
        errors++;
        $display("FAIL R1 chain byte %0d: got %02h expected %02h", i, d_out, full[i*8 +: 8]);
      end
    end
    check("R1 chain carry", {df_out, 8'h00}, {full[32], 8'h00});
    s = a - b;
    for (int i = 0; i < 4; i++) begin
      run("R3 chain", (i == 0) ? 4'h7 : 4'hB, a[i*8 +: 8], b[i*8 +: 8], (i == 0) ? 1'b0 : df_out);
      checks++;
      if (d_out !== s[i*8 +: 8]) begin
        errors++;
        $display("FAIL R3 chain byte %0d: got %02h expected %02h", i, d_out, s[i*8 +: 8]);
      end
    end
    check("R3 chain no-borrow", {df_out, 8'h00}, {a >= b, 8'h00});
    f = 1'b1;
    run("R5 ring start", 4'h0, 8'h00, 8'hB4, f);
    for (int i = 0; i < 9; i++) run("R5 ring step", 4'hC, d_out, 8'h00, df_out);
    check("R5 ring return", {df_out, d_out}, {f, 8'hB4});
  endtask

  initial begin
    t_reset();
    t_logic();
    t_add();
    t_sub();
    t_shift();
    t_hold();
    t_chain();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule